// File: doc/BRIEF.md
# System Reset Sequencer

This block decides when the chip is in reset and for how long. Three requests can start a reset: a level-sensitive external reset input, a one-cycle timeout pulse from the software watchdog, and a write of 1 to a soft-reset control bit. An accepted request drives an active-high external reset output for a fixed pulse length (`PULSE`, 128 clocks by default). It also drives one reset enable per internal peripheral group and a separate reset for the memory controller. The controller's own power-on reset (`por_n_i`) only initialises its state.

A soft reset spares the system-critical groups named in the `KEEP_MASK` parameter. The memory controller is reset only when the `mem_keep_i` strap is low; with the strap high it keeps running and refreshing. The soft-reset bit clears itself when its pulse ends, so software can poll it. A source field records which request caused the last accepted reset. Once a reset starts, bus outputs are held at their defaults. They stay held after the reset output falls, until the core reports its first bus cycle. A one-cycle strobe tells the configuration logic to re-sample the mode pins, and it fires only after an external reset.

There is no data stream here. All pins are plain control and status signals, and every register write is accepted in the cycle it is presented, with no back-pressure.

Top module: `sys_reset_sequencer`

## Requirements
- R1: A soft or watchdog reset accepted at a clock edge drives `rst_out_o` high for exactly `PULSE` cycles, starting in the cycle that follows that edge.
- R2: `reg_rdata_o[0]` (soft reset busy) reads 1 only while a soft-reset pulse is running. It returns to 0 in the same cycle that `rst_out_o` falls.
- R3: During a soft reset, `periph_rst_o[g]` stays 0 for each group g whose `KEEP_MASK` bit is 1 (groups 0 to 3 by default) and is 1 for every other group. During an external or watchdog reset, all groups are 1.
- R4: `mem_rst_o` follows `rst_out_o` while `mem_keep_i` is low and stays 0 while `mem_keep_i` is high, whatever the reset source.
- R5: `reg_rdata_o[2:1]` holds the reset source code. The codes are 00 after power-on, 01 for external, 10 for watchdog and 11 for soft. The code changes only when a new reset is accepted.
- R6: A high `ext_rst_i` is accepted at every edge, ahead of any watchdog or soft request in the same cycle. It reloads the counter, so `rst_out_o` stays high for `PULSE` cycles after the last edge at which `ext_rst_i` was high.
- R7: A watchdog or soft request that arrives while a pulse is running is ignored: the pulse length and the source code do not change. If a watchdog timeout and a soft write arrive in the same idle cycle, the watchdog wins.
- R8: `mode_sample_o` is high for exactly one cycle, the first cycle after an external reset pulse ends. It never fires after a watchdog or soft reset.
- R9: `bus_quiet_o` rises together with `rst_out_o`. It stays high after `rst_out_o` falls until `first_bus_i` is sampled high while no pulse runs, and then falls in the next cycle.
- R10: A soft reset starts only when `reg_wr_i` is high with `reg_wdata_i` = 1. A write of 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Active-low power-on reset of the sequencer itself |
| ext_rst_i | input | 1 | External reset request, active high, level |
| wdog_expire_i | input | 1 | Watchdog timeout, one-cycle pulse |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 1 | Soft-reset bit write value |
| mem_keep_i | input | 1 | Strap: 1 keeps the memory controller out of reset |
| first_bus_i | input | 1 | Core has started its first bus cycle |
| rst_out_o | output | 1 | External reset output, active high |
| periph_rst_o | output | NGRP | Per-group internal reset enables |
| mem_rst_o | output | 1 | Memory controller reset |
| mode_sample_o | output | 1 | One-cycle mode-pin re-sample strobe |
| bus_quiet_o | output | 1 | Hold bus outputs at default levels |
| reg_rdata_o | output | 3 | {source code[1:0], soft busy} |

## Verification
The assertions assume that `ext_rst_i`, `wdog_expire_i`, `reg_wr_i` and the strap are synchronous to `clk_i` and stable around each rising edge. They also assume that `first_bus_i` has meaning only after the reset output has dropped. The stimulus changes every input on the falling edge, one half period away from the sampling edge. It raises `first_bus_i` during a pulse as well as after one, so the rule that it is ignored while a pulse runs is exercised. Overlapping requests are issued on purpose, both within the same cycle and in the middle of a pulse, so that the priority and ignore rules are driven rather than assumed.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_EXT  = 2'd1,
    K_WDOG = 2'd2,
    K_SOFT = 2'd3
  } rsq_kind_e;

  localparam logic [1:0] SRC_NONE = 2'b00;
  localparam logic [1:0] SRC_EXT  = 2'b01;
  localparam logic [1:0] SRC_WDOG = 2'b10;
  localparam logic [1:0] SRC_SOFT = 2'b11;
endpackage

// File: rtl/rsq_arbiter.sv
module rsq_arbiter
  import rsq_pkg::*;
#(
  parameter int PULSE = 128
) (
  input  logic      clk_i,
  input  logic      por_n_i,
  input  logic      ext_i,
  input  logic      wdog_i,
  input  logic      soft_i,
  output logic      active_o,
  output logic      start_o,
  output rsq_kind_e kind_o,
  output logic [1:0] src_o,
  output logic      mode_stb_o
);
  localparam int CW = $clog2(PULSE + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE);

  logic [CW-1:0] cnt_q;
  rsq_kind_e     kind_q;
  logic [1:0]    src_q;
  logic          stb_q;
  logic          idle;

  assign idle     = (cnt_q == '0);
  assign start_o  = ext_i | (idle & (wdog_i | soft_i));
  assign active_o = !idle;
  assign kind_o   = kind_q;
  assign src_o    = src_q;
  assign mode_stb_o = stb_q;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      cnt_q  <= '0;
      kind_q <= K_NONE;
      src_q  <= SRC_NONE;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= (cnt_q == CW'(1)) && (kind_q == K_EXT) && !ext_i;
      if (ext_i) begin
        cnt_q  <= LOAD;
        kind_q <= K_EXT;
        src_q  <= SRC_EXT;
      end else if (idle && wdog_i) begin
        cnt_q  <= LOAD;
        kind_q <= K_WDOG;
        src_q  <= SRC_WDOG;
      end else if (idle && soft_i) begin
        cnt_q  <= LOAD;
        kind_q <= K_SOFT;
        src_q  <= SRC_SOFT;
      end else if (!idle) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R6: external request always reloads the full pulse
  p_ext_restart_r6: assert property (@(posedge clk_i) disable iff (!por_n_i)
    ext_i |=> (cnt_q == LOAD));
  // R7: while a pulse runs, only external reset may touch the source code
  p_busy_ignores_r7: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (active_o && !ext_i) |=> $stable(src_q));
  // R8: strobe lasts a single cycle
  p_strobe_single_r8: assert property (@(posedge clk_i) disable iff (!por_n_i)
    mode_stb_o |=> !mode_stb_o);
endmodule

// File: rtl/rsq_fanout.sv
module rsq_fanout
  import rsq_pkg::*;
#(
  parameter int              NGRP      = 8,
  parameter logic [NGRP-1:0] KEEP_MASK = '0
) (
  input  logic            clk_i,
  input  logic            por_n_i,
  input  logic            active_i,
  input  rsq_kind_e       kind_i,
  input  logic            mem_keep_i,
  output logic [NGRP-1:0] periph_rst_o,
  output logic            mem_rst_o
);
  logic soft_now;
  assign soft_now = (kind_i == K_SOFT);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    if (KEEP_MASK[g]) begin : g_kept
      assign periph_rst_o[g] = active_i && !soft_now;
    end else begin : g_plain
      assign periph_rst_o[g] = active_i;
    end
  end

  assign mem_rst_o = active_i && !mem_keep_i;

  // R3: protected groups never see a soft reset
  p_soft_spares_r3: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (active_i && soft_now) |-> ((periph_rst_o & KEEP_MASK) == '0));
  // R4: strap high keeps the memory controller running
  p_mem_strap_r4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    mem_keep_i |-> !mem_rst_o);
endmodule

// File: rtl/rsq_quiet.sv
module rsq_quiet (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic start_i,
  input  logic active_i,
  input  logic first_bus_i,
  output logic quiet_o
);
  logic quiet_q;
  assign quiet_o = quiet_q;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i)                           quiet_q <= 1'b0;
    else if (start_i)                       quiet_q <= 1'b1;
    else if (!active_i && first_bus_i)      quiet_q <= 1'b0;
  end

  // R9: the hold is released only by a bus cycle outside a pulse
  p_quiet_release_r9: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (quiet_q && active_i) |=> quiet_q);
endmodule

// File: rtl/sys_reset_sequencer.sv
module sys_reset_sequencer
  import rsq_pkg::*;
#(
  parameter int              PULSE     = 128,
  parameter int              NGRP      = 8,
  parameter logic [NGRP-1:0] KEEP_MASK = NGRP'(8'h0F)
) (
  input  logic            clk_i,
  input  logic            por_n_i,
  input  logic            ext_rst_i,
  input  logic            wdog_expire_i,
  input  logic            reg_wr_i,
  input  logic            reg_wdata_i,
  input  logic            mem_keep_i,
  input  logic            first_bus_i,
  output logic            rst_out_o,
  output logic [NGRP-1:0] periph_rst_o,
  output logic            mem_rst_o,
  output logic            mode_sample_o,
  output logic            bus_quiet_o,
  output logic [2:0]      reg_rdata_o
);
  logic      active, start, soft_req;
  rsq_kind_e kind;
  logic [1:0] src;

  assign soft_req = reg_wr_i && reg_wdata_i;

  rsq_arbiter #(.PULSE(PULSE)) u_arb (
    .clk_i(clk_i), .por_n_i(por_n_i), .ext_i(ext_rst_i), .wdog_i(wdog_expire_i),
    .soft_i(soft_req), .active_o(active), .start_o(start), .kind_o(kind),
    .src_o(src), .mode_stb_o(mode_sample_o)
  );

  rsq_fanout #(.NGRP(NGRP), .KEEP_MASK(KEEP_MASK)) u_fan (
    .clk_i(clk_i), .por_n_i(por_n_i), .active_i(active), .kind_i(kind),
    .mem_keep_i(mem_keep_i), .periph_rst_o(periph_rst_o), .mem_rst_o(mem_rst_o)
  );

  rsq_quiet u_quiet (
    .clk_i(clk_i), .por_n_i(por_n_i), .start_i(start), .active_i(active),
    .first_bus_i(first_bus_i), .quiet_o(bus_quiet_o)
  );

  assign rst_out_o   = active;
  assign reg_rdata_o = {src, active && (kind == K_SOFT)};

  // R9: bus outputs are held whenever the reset output is driven
  p_quiet_covers_r9: assert property (@(posedge clk_i) disable iff (!por_n_i)
    rst_out_o |-> bus_quiet_o);
  // R2: busy bit never outlives the pulse
  p_busy_in_pulse_r2: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $fell(rst_out_o) |-> !reg_rdata_o[0]);
endmodule

// File: tb/test_sys_reset_sequencer.sv
module test_sys_reset_sequencer;
  localparam int P = 128;
  localparam int G = 8;
  localparam logic [G-1:0] KEEP = 8'h0F;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic ext = 0, wd = 0, wr = 0, wdat = 0, keep = 1, fb = 0;
  logic rst_out, mem_rst, mode_s, quiet;
  logic [G-1:0] prst;
  logic [2:0] rdata;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  sys_reset_sequencer #(.PULSE(P), .NGRP(G), .KEEP_MASK(KEEP)) i_sys_reset_sequencer (
    .clk_i(clk), .por_n_i(por_n), .ext_rst_i(ext), .wdog_expire_i(wd),
    .reg_wr_i(wr), .reg_wdata_i(wdat), .mem_keep_i(keep), .first_bus_i(fb),
    .rst_out_o(rst_out), .periph_rst_o(prst), .mem_rst_o(mem_rst),
    .mode_sample_o(mode_s), .bus_quiet_o(quiet), .reg_rdata_o(rdata)
  );

  // behavioural reference: remaining cycles, cause (1 ext, 2 wdog, 3 soft)
  int m_rem = 0, m_kind = 0, m_src = 0;
  bit m_quiet = 0, m_stb = 0;

  always @(posedge clk) begin
    if (!por_n) begin
      m_rem <= 0; m_kind <= 0; m_src <= 0; m_quiet <= 0; m_stb <= 0;
    end else begin
      m_stb <= (m_rem == 1) && (m_kind == 1) && !ext;
      if (ext) begin
        m_rem <= P; m_kind <= 1; m_src <= 1; m_quiet <= 1;
      end else if (m_rem == 0 && wd) begin
        m_rem <= P; m_kind <= 2; m_src <= 2; m_quiet <= 1;
      end else if (m_rem == 0 && wr && wdat) begin
        m_rem <= P; m_kind <= 3; m_src <= 3; m_quiet <= 1;
      end else if (m_rem > 0) begin
        m_rem <= m_rem - 1;
      end else if (fb) begin
        m_quiet <= 0;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [G-1:0] e_prst;
    #1;
    cyc++;
    for (int g = 0; g < G; g++)
      e_prst[g] = (m_rem > 0) && !(m_kind == 3 && KEEP[g]);
    check("R1 rst_out", int'(rst_out), int'(m_rem > 0));
    check("R2 soft busy", int'(rdata[0]), int'(m_rem > 0 && m_kind == 3));
    check("R3 group resets", int'(prst), int'(e_prst));
    check("R4 mem reset", int'(mem_rst), int'(m_rem > 0 && !keep));
    check("R5 source code", int'(rdata[2:1]), m_src);
    check("R8 mode strobe", int'(mode_s), int'(m_stb));
    check("R9 bus quiet", int'(quiet), int'(m_quiet));
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // count cycles of rst_out high, sampled on falling edges
  task automatic measure(string tag, int exp);
    int len = 0;
    while (rst_out) begin len++; @(negedge clk); end
    check(tag, len, exp);
  endtask

  task automatic bus_go;
    fb = 1; tick(1); fb = 0; tick(2);
  endtask

  initial begin
    tick(3);
    check("R5 reset state source", int'(rdata), 0);
    check("R1 reset state output", int'(rst_out), 0);
    por_n = 1; tick(2);

    // R10: writing 0 does nothing
    wr = 1; wdat = 0; tick(1); wr = 0; tick(1);
    check("R10 zero write idle", int'(rst_out), 0);

    // soft reset, strap high
    wr = 1; wdat = 1; tick(1); wr = 0; wdat = 0;
    check("R2 busy after write", int'(rdata[0]), 1);
    fb = 1; tick(1); fb = 0;               // ignored during pulse
    measure("R1 soft pulse length", P - 1);
    check("R2 busy cleared", int'(rdata[0]), 0);
    check("R9 held after pulse", int'(quiet), 1);
    tick(3);
    bus_go;

    // watchdog, strap low, requests in the middle ignored
    keep = 0;
    wd = 1; tick(1); wd = 0;
    tick(20);
    wd = 1; wr = 1; wdat = 1; tick(1); wd = 0; wr = 0; wdat = 0;
    measure("R7 wdog pulse length", P - 21);
    check("R7 source kept", int'(rdata[2:1]), 2);
    bus_go;

    // same-cycle watchdog and soft write while idle
    wd = 1; wr = 1; wdat = 1; tick(1); wd = 0; wr = 0; wdat = 0;
    check("R7 wdog beats soft", int'(rdata[2:1]), 2);
    measure("R1 wdog pulse", P);
    bus_go;

    // external reset with simultaneous watchdog, held 5 cycles
    keep = 1;
    ext = 1; wd = 1; tick(1); wd = 0; tick(4); ext = 0;
    check("R6 ext wins", int'(rdata[2:1]), 1);
    measure("R6 pulse after release", P);
    check("R8 strobe after ext", int'(mode_s), 1);
    bus_go;

    // external reset arriving during a soft pulse restarts the count
    wr = 1; wdat = 1; tick(1); wr = 0; wdat = 0;
    tick(30);
    ext = 1; tick(1); ext = 0;
    check("R6 soft busy overridden", int'(rdata[0]), 0);
    measure("R6 restarted pulse", P);
    bus_go;

    tick(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule